// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block is the top-level controller that brings up a serial link split into two halves (even and odd) between a local and a remote endpoint. On a start request it runs a fixed pre-training sequence. It initialises the transmit FIFOs at both ends and locks clock recovery from each end in turn. It then drives a run-length pattern from both ends, has the unused lanes powered down, lets the pattern settle, and has the received lanes checked at each end. Last, it hands off to data-link training with per-half control writes.

The work itself is done by three subordinate engines (FIFO init, lane power-down and lane check) and by an external delay timer. The block talks to each of them through start-strobe and done/error handshakes. The one-time lane check is skipped when the caller reports that the link was already checked. The caller re-arms the check by clearing that flag. A link that is not marked active completes at once. An engine error aborts the run, returns all transmit words to idle and reports which step failed.

Top module: `lnk_bringup_seq`

## Requirements
- R1: A start request is taken only while the sequencer is idle. A start pulse during a run changes neither the order of steps nor the outcome.
- R2: The half-link mode is decoded as 00 = both halves, 01 = even only, 10 = odd only, 11 = both halves. The transmit words of a disabled half stay zero throughout.
- R3: Each transmit word is 0x4444444444400000 for pattern A, 0x1111111111100000 for the training-sequence-1 pattern, and zero for idle.
- R4: On an unchecked active link the steps run in this order: local FIFO init, remote FIFO init, local clock-recovery lock, remote clock-recovery lock, pattern A from both ends with lane power-down, settle delay, remote lane check, local lane check, checked mark, final local clock-recovery lock, training writes.
- R5: When checked_i is set at start, the run goes straight to the final local clock-recovery lock and then to the training writes.
- R6: During a clock-recovery lock only the locking end sends training-sequence-1, on its enabled halves, while one timer request is outstanding. Its words return to idle when the timer completes.
- R7: The first training write has data equal to mask. The mask holds the phy-training bit of each enabled half (bit 0 even, bit 1 odd).
- R8: In recovery mode a second write follows. Its data keeps the phy-training bits and adds the startup bit of each enabled half (bit 2 even, bit 3 odd). Its mask holds only those startup bits.
- R9: With train_skip_i set at start, no training write is issued, and all other steps still run.
- R10: When link_active_i is low at start, done_o pulses on the next cycle and no engine, timer or write activity takes place.
- R11: An engine error aborts the run, pulses err_o and drives all transmit words to zero. err_code_o names the failing step (1 local FIFO, 2 remote FIFO, 3 power-down, 4 remote check, 5 local check) and holds it until the next accepted start.
- R12: done_o is a single-cycle pulse and is never high together with err_o.
- R13: checked_set_o pulses once, after both lane checks pass and before the final clock-recovery lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when idle |
| link_mode_i | input | 2 | Half-link mode (00 both, 01 even, 10 odd, 11 both) |
| link_active_i | input | 1 | Link is marked active |
| recovery_i | input | 1 | Recovery mode: add startup write |
| checked_i | input | 1 | One-time lane check already done |
| train_skip_i | input | 1 | Suppress training-start writes |
| tmr_done_i | input | 1 | Delay timer expired |
| tmr_start_o | output | 1 | Delay timer request pulse |
| eng_done_i | input | 3 | Engine done (0 FIFO, 1 power-down, 2 check) |
| eng_err_i | input | 3 | Engine error, same indexing |
| eng_start_o | output | 3 | Engine start pulses, same indexing |
| eng_remote_o | output | 1 | Started engine targets the remote end |
| loc_even_o | output | 64 | Local end, even half transmit word |
| loc_odd_o | output | 64 | Local end, odd half transmit word |
| rem_even_o | output | 64 | Remote end, even half transmit word |
| rem_odd_o | output | 64 | Remote end, odd half transmit word |
| ctl_wr_o | output | 1 | Training control write strobe |
| ctl_data_o | output | 4 | Control write data |
| ctl_mask_o | output | 4 | Control write mask |
| checked_set_o | output | 1 | Mark both ends as checked |
| done_o | output | 1 | Run complete pulse |
| err_o | output | 1 | Run aborted pulse |
| err_code_o | output | 3 | Failing step code |

## Verification
Every output is a register loaded from the state transition, so an action appears one cycle after the edge that sees its cause. Engine and timer strobes follow a start or a handshake by one cycle. done_o after an inactive-link start also follows by one cycle, and a transmit word changes in the same cycle as the step that selects it. The bench drives inputs and samples outputs on the falling edge, half a cycle after each rising edge. It answers each strobe after a fixed latency and records each action in order into an event log, which is compared whole against the expected ordering. Pulse width, word values and error codes are checked in the exact cycle in which the pulse is observed.

// File: rtl/lnk_bringup_pkg.sv
package lnk_bringup_pkg;

    localparam int unsigned NUM_ENG = 3;
    localparam int unsigned ENG_FIFO = 0;
    localparam int unsigned ENG_PDWN = 1;
    localparam int unsigned ENG_CHK  = 2;
    localparam int unsigned CTL_W    = 4;
    localparam int unsigned ERRC_W   = 3;

    localparam logic [ERRC_W-1:0] ERRC_NONE   = 3'd0;
    localparam logic [ERRC_W-1:0] ERRC_FIFO_L = 3'd1;
    localparam logic [ERRC_W-1:0] ERRC_FIFO_R = 3'd2;
    localparam logic [ERRC_W-1:0] ERRC_PDWN   = 3'd3;
    localparam logic [ERRC_W-1:0] ERRC_CHK_R  = 3'd4;
    localparam logic [ERRC_W-1:0] ERRC_CHK_L  = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE, S_FIFO_L, S_FIFO_R, S_CDR_L, S_CDR_R, S_PDWN, S_SETTLE,
        S_CHK_R, S_CHK_L, S_MARK, S_CDR_F, S_TRAIN1, S_TRAIN2
    } seq_state_e;

    typedef enum logic [1:0] {
        PAT_IDLE, PAT_TS1, PAT_A
    } tx_pat_e;

    typedef struct packed {
        seq_state_e         st;
        logic               en_even;
        logic               en_odd;
        logic               recov;
        logic               no_train;
        tx_pat_e            loc_pat;
        tx_pat_e            rem_pat;
        logic [NUM_ENG-1:0] eng_start;
        logic               eng_remote;
        logic               tmr_start;
        logic               ctl_wr;
        logic [CTL_W-1:0]   ctl_data;
        logic [CTL_W-1:0]   ctl_mask;
        logic               mark;
        logic               done;
        logic               err;
        logic [ERRC_W-1:0]  err_code;
    } seq_regs_t;

endpackage

// File: rtl/lnk_mode_decode.sv
module lnk_mode_decode (
    input  logic [1:0] mode_i,
    output logic       even_o,
    output logic       odd_o
);
    // 01 selects even only, 10 odd only; 00 and 11 enable both halves
    always_comb begin
        even_o = (mode_i != 2'b10);
        odd_o  = (mode_i != 2'b01);
    end
endmodule

// File: rtl/lnk_pat_drive.sv
module lnk_pat_drive
    import lnk_bringup_pkg::*;
#(
    parameter int unsigned          WORD_W   = 64,
    parameter logic [WORD_W-1:0]    A_WORD   = 64'h4444444444400000,
    parameter logic [WORD_W-1:0]    TS1_WORD = 64'h1111111111100000
) (
    input  tx_pat_e             pat_i,
    input  logic [1:0]          half_en_i,
    output logic [2*WORD_W-1:0] words_o
);
    localparam int unsigned HALVES = 2;

    logic [WORD_W-1:0] sel_word;

    always_comb begin
        unique case (pat_i)
            PAT_TS1: sel_word = TS1_WORD;
            PAT_A:   sel_word = A_WORD;
            default: sel_word = '0;
        endcase
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign words_o[h*WORD_W +: WORD_W] = half_en_i[h] ? sel_word : '0;
    end
endmodule

// File: rtl/lnk_seq_fsm.sv
module lnk_seq_fsm
    import lnk_bringup_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               en_even_i,
    input  logic               en_odd_i,
    input  logic               link_active_i,
    input  logic               recovery_i,
    input  logic               checked_i,
    input  logic               train_skip_i,
    input  logic               tmr_done_i,
    input  logic [NUM_ENG-1:0] eng_done_i,
    input  logic [NUM_ENG-1:0] eng_err_i,
    output seq_regs_t          regs_o
);
    seq_regs_t q, d;

    // Load the outputs that belong to a step on entry into it
    function automatic seq_regs_t enter(input seq_regs_t s, input seq_state_e nx);
        seq_regs_t r;
        r         = s;
        r.st      = nx;
        r.loc_pat = PAT_IDLE;
        r.rem_pat = PAT_IDLE;
        unique case (nx)
            S_FIFO_L: begin r.eng_start[ENG_FIFO] = 1'b1; r.eng_remote = 1'b0; end
            S_FIFO_R: begin r.eng_start[ENG_FIFO] = 1'b1; r.eng_remote = 1'b1; end
            S_CDR_L:  begin r.loc_pat = PAT_TS1; r.tmr_start = 1'b1; end
            S_CDR_R:  begin r.rem_pat = PAT_TS1; r.tmr_start = 1'b1; end
            S_PDWN: begin
                r.loc_pat = PAT_A; r.rem_pat = PAT_A;
                r.eng_start[ENG_PDWN] = 1'b1; r.eng_remote = 1'b0;
            end
            S_SETTLE: begin r.loc_pat = PAT_A; r.rem_pat = PAT_A; r.tmr_start = 1'b1; end
            S_CHK_R: begin
                r.loc_pat = PAT_A; r.rem_pat = PAT_A;
                r.eng_start[ENG_CHK] = 1'b1; r.eng_remote = 1'b1;
            end
            S_CHK_L: begin
                r.loc_pat = PAT_A; r.rem_pat = PAT_A;
                r.eng_start[ENG_CHK] = 1'b1; r.eng_remote = 1'b0;
            end
            S_MARK:   r.mark = 1'b1;
            S_CDR_F:  begin r.loc_pat = PAT_TS1; r.tmr_start = 1'b1; end
            S_TRAIN1: begin
                r.ctl_wr   = 1'b1;
                r.ctl_data = {2'b00, s.en_odd, s.en_even};
                r.ctl_mask = {2'b00, s.en_odd, s.en_even};
            end
            S_TRAIN2: begin
                r.ctl_wr   = 1'b1;
                r.ctl_data = {s.en_odd, s.en_even, s.en_odd, s.en_even};
                r.ctl_mask = {s.en_odd, s.en_even, 2'b00};
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic seq_regs_t finish(input seq_regs_t s);
        seq_regs_t r;
        r      = enter(s, S_IDLE);
        r.done = 1'b1;
        return r;
    endfunction

    function automatic seq_regs_t abort(input seq_regs_t s, input logic [ERRC_W-1:0] code);
        seq_regs_t r;
        r          = enter(s, S_IDLE);
        r.err      = 1'b1;
        r.err_code = code;
        return r;
    endfunction

    // Wait on one engine: error wins over done in the same cycle
    function automatic seq_regs_t eng_wait(input seq_regs_t s, input int unsigned idx,
                                           input logic [ERRC_W-1:0] code,
                                           input seq_state_e nx,
                                           input logic [NUM_ENG-1:0] dn,
                                           input logic [NUM_ENG-1:0] er);
        seq_regs_t r;
        r = s;
        if (er[idx])      r = abort(s, code);
        else if (dn[idx]) r = enter(s, nx);
        return r;
    endfunction

    always_comb begin
        d           = q;
        d.eng_start = '0;
        d.tmr_start = 1'b0;
        d.ctl_wr    = 1'b0;
        d.mark      = 1'b0;
        d.done      = 1'b0;
        d.err       = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.en_even  = en_even_i;
                    d.en_odd   = en_odd_i;
                    d.recov    = recovery_i;
                    d.no_train = train_skip_i;
                    d.err_code = ERRC_NONE;
                    if (!link_active_i) d.done = 1'b1;
                    else if (checked_i) d = enter(d, S_CDR_F);
                    else                d = enter(d, S_FIFO_L);
                end
            end
            S_FIFO_L: d = eng_wait(d, ENG_FIFO, ERRC_FIFO_L, S_FIFO_R, eng_done_i, eng_err_i);
            S_FIFO_R: d = eng_wait(d, ENG_FIFO, ERRC_FIFO_R, S_CDR_L, eng_done_i, eng_err_i);
            S_CDR_L:  if (tmr_done_i) d = enter(d, S_CDR_R);
            S_CDR_R:  if (tmr_done_i) d = enter(d, S_PDWN);
            S_PDWN:   d = eng_wait(d, ENG_PDWN, ERRC_PDWN, S_SETTLE, eng_done_i, eng_err_i);
            S_SETTLE: if (tmr_done_i) d = enter(d, S_CHK_R);
            S_CHK_R:  d = eng_wait(d, ENG_CHK, ERRC_CHK_R, S_CHK_L, eng_done_i, eng_err_i);
            S_CHK_L:  d = eng_wait(d, ENG_CHK, ERRC_CHK_L, S_MARK, eng_done_i, eng_err_i);
            S_MARK:   d = enter(d, S_CDR_F);
            S_CDR_F: begin
                if (tmr_done_i) d = q.no_train ? finish(d) : enter(d, S_TRAIN1);
            end
            S_TRAIN1: d = q.recov ? enter(d, S_TRAIN2) : finish(d);
            S_TRAIN2: d = finish(d);
            default:  d = enter(d, S_IDLE);
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q          <= '0;
            q.st       <= S_IDLE;
            q.loc_pat  <= PAT_IDLE;
            q.rem_pat  <= PAT_IDLE;
        end else begin
            q <= d;
        end
    end

    assign regs_o = q;

    // R12: completion and abort never coincide
    a_r12_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(q.done && q.err));
    // R12: done lasts one cycle
    a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |=> !q.done);
    // R4: at most one engine is started at a time
    a_r4_one_engine: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(q.eng_start));
    // R4: an engine strobe only accompanies a step change
    a_r4_start_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|q.eng_start) |-> (q.st != $past(q.st)));
    // R8: the startup write never touches phy-training bits
    a_r8_startup_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.ctl_wr && (|q.ctl_mask[3:2])) |-> (q.ctl_mask[1:0] == 2'b00));
    // R1: a start pulse while busy keeps the step unchanged unless a handshake arrives
    a_r1_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == S_CDR_L && start_i && !tmr_done_i) |=> (q.st == S_CDR_L));
endmodule

// File: rtl/lnk_bringup_seq.sv
module lnk_bringup_seq
    import lnk_bringup_pkg::*;
#(
    parameter int unsigned       WORD_W   = 64,
    parameter logic [WORD_W-1:0] A_WORD   = 64'h4444444444400000,
    parameter logic [WORD_W-1:0] TS1_WORD = 64'h1111111111100000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        link_mode_i,
    input  logic              link_active_i,
    input  logic              recovery_i,
    input  logic              checked_i,
    input  logic              train_skip_i,
    input  logic              tmr_done_i,
    output logic              tmr_start_o,
    input  logic [2:0]        eng_done_i,
    input  logic [2:0]        eng_err_i,
    output logic [2:0]        eng_start_o,
    output logic              eng_remote_o,
    output logic [WORD_W-1:0] loc_even_o,
    output logic [WORD_W-1:0] loc_odd_o,
    output logic [WORD_W-1:0] rem_even_o,
    output logic [WORD_W-1:0] rem_odd_o,
    output logic              ctl_wr_o,
    output logic [3:0]        ctl_data_o,
    output logic [3:0]        ctl_mask_o,
    output logic              checked_set_o,
    output logic              done_o,
    output logic              err_o,
    output logic [2:0]        err_code_o
);
    logic              mode_even, mode_odd;
    seq_regs_t         regs;
    logic [2*WORD_W-1:0] loc_words, rem_words;

    lnk_mode_decode i_mode (
        .mode_i (link_mode_i),
        .even_o (mode_even),
        .odd_o  (mode_odd)
    );

    lnk_seq_fsm i_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_i       (start_i),
        .en_even_i     (mode_even),
        .en_odd_i      (mode_odd),
        .link_active_i (link_active_i),
        .recovery_i    (recovery_i),
        .checked_i     (checked_i),
        .train_skip_i  (train_skip_i),
        .tmr_done_i    (tmr_done_i),
        .eng_done_i    (eng_done_i),
        .eng_err_i     (eng_err_i),
        .regs_o        (regs)
    );

    lnk_pat_drive #(.WORD_W(WORD_W), .A_WORD(A_WORD), .TS1_WORD(TS1_WORD)) i_loc_pat (
        .pat_i     (regs.loc_pat),
        .half_en_i ({regs.en_odd, regs.en_even}),
        .words_o   (loc_words)
    );

    lnk_pat_drive #(.WORD_W(WORD_W), .A_WORD(A_WORD), .TS1_WORD(TS1_WORD)) i_rem_pat (
        .pat_i     (regs.rem_pat),
        .half_en_i ({regs.en_odd, regs.en_even}),
        .words_o   (rem_words)
    );

    assign loc_even_o    = loc_words[WORD_W-1:0];
    assign loc_odd_o     = loc_words[2*WORD_W-1:WORD_W];
    assign rem_even_o    = rem_words[WORD_W-1:0];
    assign rem_odd_o     = rem_words[2*WORD_W-1:WORD_W];
    assign tmr_start_o   = regs.tmr_start;
    assign eng_start_o   = regs.eng_start;
    assign eng_remote_o  = regs.eng_remote;
    assign ctl_wr_o      = regs.ctl_wr;
    assign ctl_data_o    = regs.ctl_data;
    assign ctl_mask_o    = regs.ctl_mask;
    assign checked_set_o = regs.mark;
    assign done_o        = regs.done;
    assign err_o         = regs.err;
    assign err_code_o    = regs.err_code;

    // R11: an abort leaves every transmit word idle
    a_r11_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> ((loc_words == '0) && (rem_words == '0)));
    // R6: every delay request runs with some pattern on the line
    a_r6_delay_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_start_o |-> ((loc_words | rem_words) != '0));
    // R10: completion never coincides with an engine strobe
    a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (eng_start_o == '0 && !tmr_start_o && !ctl_wr_o));
endmodule

// File: tb/test_lnk_bringup_seq.sv
module test_lnk_bringup_seq;

    localparam logic [63:0] PA  = 64'h4444444444400000;
    localparam logic [63:0] TS1 = 64'h1111111111100000;

    typedef struct packed {
        logic [1:0]  mode;
        logic        act;
        logic        rec;
        logic        chk;
        logic        skip;
        logic [3:0]  err_at;
        logic [63:0] exp_log;
        logic [2:0]  exp_code;
    } vec_t;

    // Event codes: 1/2 FIFO init local/remote, 3/4 lock local/remote,
    // 5 power-down, 6 settle with pattern A, 7/8 check remote/local,
    // 9 mark, B first write, C second write, D done, E error
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 64'h1234567893BCD, 3'd0},
        '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 64'h1234567893BD,  3'd0},
        '{2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 64'h3BCD,          3'd0},
        '{2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 64'h3BD,           3'd0},
        '{2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 64'hD,             3'd0},
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 64'h1234567893D,   3'd0},
        '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 4'h1, 64'h1E,            3'd1},
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 4'h2, 64'h12E,           3'd2},
        '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 64'h12345E,        3'd3},
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 4'h7, 64'h1234567E,      3'd4},
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 4'h8, 64'h12345678E,     3'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  link_mode_i = 2'b00;
    logic        link_active_i = 1'b0, recovery_i = 1'b0, checked_i = 1'b0, train_skip_i = 1'b0;
    logic        tmr_done_i = 1'b0;
    logic [2:0]  eng_done_i = '0, eng_err_i = '0;
    logic        tmr_start_o, eng_remote_o, ctl_wr_o, checked_set_o, done_o, err_o;
    logic [2:0]  eng_start_o, err_code_o;
    logic [63:0] loc_even_o, loc_odd_o, rem_even_o, rem_odd_o;
    logic [3:0]  ctl_data_o, ctl_mask_o;

    int tests = 0, fails = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    lnk_bringup_seq i_lnk_bringup_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .link_mode_i(link_mode_i),
        .link_active_i(link_active_i), .recovery_i(recovery_i), .checked_i(checked_i),
        .train_skip_i(train_skip_i), .tmr_done_i(tmr_done_i), .tmr_start_o(tmr_start_o),
        .eng_done_i(eng_done_i), .eng_err_i(eng_err_i), .eng_start_o(eng_start_o),
        .eng_remote_o(eng_remote_o), .loc_even_o(loc_even_o), .loc_odd_o(loc_odd_o),
        .rem_even_o(rem_even_o), .rem_odd_o(rem_odd_o), .ctl_wr_o(ctl_wr_o),
        .ctl_data_o(ctl_data_o), .ctl_mask_o(ctl_mask_o), .checked_set_o(checked_set_o),
        .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input vec_t v, input int poke, input string tag);
        logic [63:0] log = '0;
        bit ev = (v.mode != 2'b10);
        bit od = (v.mode != 2'b01);
        bit fin = 1'b0;
        int e_cnt = 0, t_cnt = 0, e_idx = 0;
        bit e_bad = 1'b0;
        logic [3:0] code;
        logic [63:0] lw, rw;
        @(negedge clk);
        link_mode_i = v.mode; link_active_i = v.act; recovery_i = v.rec;
        checked_i = v.chk; train_skip_i = v.skip; start_i = 1'b1;
        for (int c = 0; c < 400 && !fin; c++) begin
            @(negedge clk);
            start_i = (c == poke);
            eng_done_i = '0; eng_err_i = '0; tmr_done_i = 1'b0;
            if (e_cnt > 0) begin
                e_cnt--;
                if (e_cnt == 0) begin
                    if (e_bad) eng_err_i[e_idx] = 1'b1;
                    else       eng_done_i[e_idx] = 1'b1;
                end
            end
            if (t_cnt > 0) begin
                t_cnt--;
                if (t_cnt == 0) tmr_done_i = 1'b1;
            end
            lw = loc_even_o | loc_odd_o;
            rw = rem_even_o | rem_odd_o;
            if (eng_start_o != 3'b000) begin
                if (eng_start_o[0])      begin code = eng_remote_o ? 4'h2 : 4'h1; e_idx = 0; end
                else if (eng_start_o[1]) begin code = 4'h5; e_idx = 1; end
                else                     begin code = eng_remote_o ? 4'h7 : 4'h8; e_idx = 2; end
                e_bad = (code == v.err_at);
                e_cnt = 3;
                log = {log[59:0], code};
            end
            if (tmr_start_o) begin
                if (lw == PA && rw == PA) begin
                    code = 4'h6;
                    chk(loc_even_o == (ev ? PA : 64'h0) && rem_odd_o == (od ? PA : 64'h0),
                        {"R3 R2 pattern A words ", tag}, loc_even_o ^ rem_odd_o, PA);
                end else if (lw == TS1 && rw == 64'h0) begin
                    code = 4'h3;
                    chk(loc_even_o == (ev ? TS1 : 64'h0) && loc_odd_o == (od ? TS1 : 64'h0),
                        {"R6 R2 local lock words ", tag}, loc_odd_o, TS1);
                end else if (rw == TS1 && lw == 64'h0) begin
                    code = 4'h4;
                    chk(rem_even_o == (ev ? TS1 : 64'h0) && rem_odd_o == (od ? TS1 : 64'h0),
                        {"R6 R2 remote lock words ", tag}, rem_odd_o, TS1);
                end else code = 4'hF;
                t_cnt = 5;
                log = {log[59:0], code};
            end
            if (checked_set_o) log = {log[59:0], 4'h9};
            if (ctl_wr_o) begin
                if (ctl_mask_o[3:2] != 2'b00) begin
                    log = {log[59:0], 4'hC};
                    chk(ctl_data_o == {od, ev, od, ev} && ctl_mask_o == {od, ev, 2'b00},
                        {"R8 startup write ", tag}, {ctl_data_o, ctl_mask_o}, {od, ev, od, ev, od, ev, 2'b00});
                end else begin
                    log = {log[59:0], 4'hB};
                    chk(ctl_data_o == {2'b00, od, ev} && ctl_mask_o == {2'b00, od, ev},
                        {"R7 training write ", tag}, {ctl_data_o, ctl_mask_o}, {2'b00, od, ev, 2'b00, od, ev});
                end
            end
            if (done_o || err_o) begin
                chk(!(done_o && err_o), {"R12 done/err exclusive ", tag}, {done_o, err_o}, 2'b10);
                fin = 1'b1;
                if (done_o) log = {log[59:0], 4'hD};
                else begin
                    log = {log[59:0], 4'hE};
                    chk(err_code_o == v.exp_code, {"R11 error code ", tag}, err_code_o, v.exp_code);
                    chk((lw | rw) == 64'h0, {"R11 idle words on abort ", tag}, lw | rw, 64'h0);
                end
            end
        end
        chk(fin, {"R4 run completes ", tag}, fin, 1);
        chk(log == v.exp_log, {"R4 R5 R9 R10 R13 step order ", tag}, log, v.exp_log);
        @(negedge clk);
        chk(!done_o && !err_o, {"R12 single-cycle status ", tag}, {done_o, err_o}, 0);
        eng_done_i = '0; eng_err_i = '0; tmr_done_i = 1'b0; start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({done_o, err_o, err_code_o, eng_start_o, tmr_start_o, ctl_wr_o, checked_set_o} == '0,
            "R12 reset status quiet", {done_o, err_o, err_code_o}, 0);
        chk((loc_even_o | loc_odd_o | rem_even_o | rem_odd_o) == 64'h0,
            "R3 reset words idle", loc_even_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            run(VECS[i], -1, $sformatf("row %0d", i));
        end
        // R1: a start pulse in mid-run is ignored
        run(VECS[0], 10, "R1 start while busy");
        run(VECS[3], 3, "R1 start during final lock");
        // R11: error code holds while idle and clears on the next start
        run(VECS[10], -1, "R11 hold");
        repeat (4) @(negedge clk);
        chk(err_code_o == 3'd5, "R11 code held while idle", err_code_o, 5);
        run(VECS[4], -1, "R11 clear");
        chk(err_code_o == 3'd0, "R11 code cleared by start", err_code_o, 0);
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule